// File: doc/BRIEF.md
# Dual-Lane Sequence Buffer with Demand-Mode Transfer Request

This block sits between two averaging lanes and a 32-bit host bus. Each lane presents 16-bit averaged samples in its own clock domain. A sample is stored only on the final pass of an averaging run. Each lane has its own dual-clock FIFO, and the two FIFOs are drained together from the bus clock domain. None of the three clocks is phase-related to the others. Each FIFO moves its pointers across the clock boundary as Gray code through multi-flop synchronizers.

When both lanes hold at least one complete averaged sequence, the block raises a transfer request. A bus-master engine outside this block then pops the sequence word by word. Each 32-bit word carries the lane A sample in bits 15:0 and the matching lane B sample in bits 31:16. The request stays up for exactly one sequence and drops after its last word. A sample that arrives at a full FIFO is dropped, and a sticky flag for that lane becomes visible in the bus domain.

Top module: `seq_dma_buffer`

## Requirements
- R1: After reset, `dma_req`, `dma_last`, `rd_avail`, `ovf_a` and `ovf_b` are all 0.
- R2: A lane stores a sample only in a cycle where its valid input and its last-average input are both 1. Any other input combination stores nothing.
- R3: `dma_req` rises only once both FIFOs hold at least SEQ_WORDS samples. With fewer samples in either lane, it stays 0 for any length of time.
- R4: Each read word is `{lane B sample, lane A sample}`, with lane A in bits 15:0.
- R5: Each lane returns its stored samples in the order they were written, and nothing is duplicated or lost.
- R6: Once raised, `dma_req` stays 1 until SEQ_WORDS words have been popped. `dma_last` is 1 exactly while the final word of the burst is presented. `dma_req` is 0 in the cycle after that word is popped.
- R7: `rd_en` has no effect while `dma_req` is 0. No word is removed.
- R8: A write to a full FIFO is dropped, and the stored data stays intact. That lane's overflow flag goes to 1 in the bus domain and stays 1 until reset.
- R9: Overflow on one lane leaves the other lane's flag at 0.
- R10: When two or more sequences are queued, `dma_req` rises again after the previous burst ends, and the next sequence is delivered in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Lane A write clock |
| rst_a_n | input | 1 | Lane A asynchronous reset, active low |
| a_valid | input | 1 | Lane A sample valid |
| a_last_avg | input | 1 | Lane A sample is from the final averaging pass |
| a_data | input | 16 | Lane A averaged sample |
| clk_b | input | 1 | Lane B write clock |
| rst_b_n | input | 1 | Lane B asynchronous reset, active low |
| b_valid | input | 1 | Lane B sample valid |
| b_last_avg | input | 1 | Lane B sample is from the final averaging pass |
| b_data | input | 16 | Lane B averaged sample |
| clk_bus | input | 1 | Bus-side read clock |
| rst_bus_n | input | 1 | Bus-side asynchronous reset, active low |
| rd_en | input | 1 | Pop the current word (honoured only while dma_req is 1) |
| rd_data | output | 32 | Packed word {lane B, lane A} |
| rd_avail | output | 1 | Both FIFOs are non-empty as seen from the bus domain |
| dma_req | output | 1 | Demand transfer request for one sequence |
| dma_last | output | 1 | Current word is the last one of the burst |
| ovf_a | output | 1 | Sticky lane A overflow, bus domain |
| ovf_b | output | 1 | Sticky lane B overflow, bus domain |

## Verification
Suppose a pointer is corrupted or its Gray encoding is wrong. The symptom shows at `rd_data` on the next burst as a skipped, repeated or misordered sample, so every word of every burst is compared against a model. A miscounted burst length shows within one sequence, as `dma_last` on the wrong word or `dma_req` still high after the last pop. A wrong full test shows within a few bus cycles of a deliberate overfill, either as a missing overflow flag or as overwritten data in the following two bursts.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
   localparam int unsigned LANES = 2;

   typedef enum logic {
      XFER_IDLE  = 1'b0,
      XFER_BURST = 1'b1
   } xfer_state_t;
endpackage

// File: rtl/sbuf_sync.sv
module sbuf_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES+1];

   assign chain[0] = d;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s+1] <= '0;
         else        chain[s+1] <= chain[s];
      end
   end

   assign q = chain[STAGES];
endmodule

// File: rtl/sbuf_afifo.sv
module sbuf_afifo #(
   parameter int unsigned DW          = 16,
   parameter int unsigned AW          = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic          wclk,
   input  logic          wrst_n,
   input  logic          wr_req,
   input  logic [DW-1:0] wdata,
   output logic          w_ovf,
   input  logic          rclk,
   input  logic          rrst_n,
   input  logic          rd_pop,
   output logic [DW-1:0] rdata,
   output logic          r_empty,
   output logic [AW:0]   r_level
);
   localparam int unsigned DEPTH = 1 << AW;

   function automatic logic [AW:0] to_gray(input logic [AW:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [AW:0] from_gray(input logic [AW:0] g);
      logic [AW:0] b;
      b[AW] = g[AW];
      for (int i = int'(AW) - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   logic [DW-1:0] mem [DEPTH];

   // write side
   logic [AW:0] wbin, wgray, rgray_w, wbin_nxt;
   logic        w_full, w_ok;

   assign w_full   = (wgray == {~rgray_w[AW:AW-1], rgray_w[AW-2:0]});
   assign w_ok     = wr_req && !w_full;
   assign wbin_nxt = wbin + (AW+1)'(w_ok);

   always_ff @(posedge wclk or negedge wrst_n) begin
      if (!wrst_n) begin
         wbin  <= '0;
         wgray <= '0;
         w_ovf <= 1'b0;
      end else begin
         wbin  <= wbin_nxt;
         wgray <= to_gray(wbin_nxt);
         if (wr_req && w_full) w_ovf <= 1'b1;
      end
   end

   always_ff @(posedge wclk) begin
      if (w_ok) mem[wbin[AW-1:0]] <= wdata;
   end

   // read side
   logic [AW:0] rbin, rgray, wgray_r, rbin_nxt;
   logic        r_ok;

   assign r_empty  = (rgray == wgray_r);
   assign r_ok     = rd_pop && !r_empty;
   assign rbin_nxt = rbin + (AW+1)'(r_ok);
   assign r_level  = from_gray(wgray_r) - rbin;
   assign rdata    = mem[rbin[AW-1:0]];

   always_ff @(posedge rclk or negedge rrst_n) begin
      if (!rrst_n) begin
         rbin  <= '0;
         rgray <= '0;
      end else begin
         rbin  <= rbin_nxt;
         rgray <= to_gray(rbin_nxt);
      end
   end

   // pointer crossings
   sbuf_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_r2w (
      .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_w)
   );
   sbuf_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_w2r (
      .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_r)
   );
endmodule

// File: rtl/sbuf_xfer_ctrl.sv
module sbuf_xfer_ctrl
   import sbuf_pkg::*;
#(
   parameter int unsigned SEQ_WORDS = 4,
   parameter int unsigned LW        = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [LW-1:0] lvl_a,
   input  logic [LW-1:0] lvl_b,
   input  logic          any_empty,
   input  logic          rd_en,
   output logic          req,
   output logic          last,
   output logic          pop
);
   localparam int unsigned CW = (SEQ_WORDS > 1) ? $clog2(SEQ_WORDS) : 1;
   localparam logic [CW-1:0] CNT_END = CW'(SEQ_WORDS - 1);
   localparam logic [LW-1:0] LVL_SEQ = LW'(SEQ_WORDS);

   xfer_state_t   state;
   logic [CW-1:0] cnt;
   logic          seq_ready;

   assign seq_ready = (lvl_a >= LVL_SEQ) && (lvl_b >= LVL_SEQ);
   assign req       = (state == XFER_BURST);
   assign last      = req && (cnt == CNT_END);
   assign pop       = rd_en && req && !any_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= XFER_IDLE;
         cnt   <= '0;
      end else begin
         unique case (state)
            XFER_IDLE: begin
               cnt <= '0;
               if (seq_ready) state <= XFER_BURST;
            end
            XFER_BURST: begin
               if (pop) begin
                  if (cnt == CNT_END) begin
                     state <= XFER_IDLE;
                     cnt   <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            default: state <= XFER_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/seq_dma_buffer.sv
module seq_dma_buffer
   import sbuf_pkg::*;
#(
   parameter int unsigned SAMPLE_W    = 16,
   parameter int unsigned DEPTH       = 1024,
   parameter int unsigned SEQ_WORDS   = 512,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                  clk_a,
   input  logic                  rst_a_n,
   input  logic                  a_valid,
   input  logic                  a_last_avg,
   input  logic [SAMPLE_W-1:0]   a_data,
   input  logic                  clk_b,
   input  logic                  rst_b_n,
   input  logic                  b_valid,
   input  logic                  b_last_avg,
   input  logic [SAMPLE_W-1:0]   b_data,
   input  logic                  clk_bus,
   input  logic                  rst_bus_n,
   input  logic                  rd_en,
   output logic [2*SAMPLE_W-1:0] rd_data,
   output logic                  rd_avail,
   output logic                  dma_req,
   output logic                  dma_last,
   output logic                  ovf_a,
   output logic                  ovf_b
);
   localparam int unsigned AW = $clog2(DEPTH);
   localparam int unsigned LW = AW + 1;

   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two, at least 4");
   end
   if (SEQ_WORDS < 2 || SEQ_WORDS > DEPTH) begin : g_bad_seq
      $error("SEQ_WORDS must lie in 2..DEPTH");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [LANES-1:0]    w_clk, w_rst_n, w_req, w_ovf, r_empty, ovf_bus;
   logic [SAMPLE_W-1:0] w_dat [LANES];
   logic [SAMPLE_W-1:0] r_dat [LANES];
   logic [LW-1:0]       r_lvl [LANES];
   logic                pop;

   assign w_clk   = {clk_b, clk_a};
   assign w_rst_n = {rst_b_n, rst_a_n};
   assign w_req   = {b_valid & b_last_avg, a_valid & a_last_avg};
   assign w_dat[0] = a_data;
   assign w_dat[1] = b_data;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      sbuf_afifo #(.DW(SAMPLE_W), .AW(AW), .SYNC_STAGES(SYNC_STAGES)) u_fifo (
         .wclk   (w_clk[g]),
         .wrst_n (w_rst_n[g]),
         .wr_req (w_req[g]),
         .wdata  (w_dat[g]),
         .w_ovf  (w_ovf[g]),
         .rclk   (clk_bus),
         .rrst_n (rst_bus_n),
         .rd_pop (pop),
         .rdata  (r_dat[g]),
         .r_empty(r_empty[g]),
         .r_level(r_lvl[g])
      );
      sbuf_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ovf_sync (
         .clk(clk_bus), .rst_n(rst_bus_n), .d(w_ovf[g]), .q(ovf_bus[g])
      );
   end

   sbuf_xfer_ctrl #(.SEQ_WORDS(SEQ_WORDS), .LW(LW)) u_ctrl (
      .clk      (clk_bus),
      .rst_n    (rst_bus_n),
      .lvl_a    (r_lvl[0]),
      .lvl_b    (r_lvl[1]),
      .any_empty(|r_empty),
      .rd_en    (rd_en),
      .req      (dma_req),
      .last     (dma_last),
      .pop      (pop)
   );

   assign rd_data  = {r_dat[1], r_dat[0]};
   assign rd_avail = ~|r_empty;
   assign ovf_a    = ovf_bus[0];
   assign ovf_b    = ovf_bus[1];
endmodule

// File: rtl/sbuf_checker.sv
module sbuf_checker #(
   parameter int unsigned SEQ_WORDS = 4
) (
   input logic clk_bus,
   input logic rst_bus_n,
   input logic rd_en,
   input logic rd_avail,
   input logic dma_req,
   input logic dma_last,
   input logic ovf_a,
   input logic ovf_b
);
   logic [31:0] pops;

   always_ff @(posedge clk_bus or negedge rst_bus_n) begin
      if (!rst_bus_n)                  pops <= '0;
      else if (rd_en && dma_last)      pops <= '0;
      else if (rd_en && dma_req)       pops <= pops + 1;
   end

   a_r3_req_has_data: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
      dma_req |-> rd_avail);
   a_r6_last_in_req: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
      dma_last |-> dma_req);
   a_r6_hold: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
      (dma_req && !(rd_en && dma_last)) |=> dma_req);
   a_r6_release: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
      (rd_en && dma_last) |=> !dma_req);
   a_r6_burst_len: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
      (rd_en && dma_last) |-> (pops == 32'(SEQ_WORDS - 1)));
   a_r8_ovf_sticky_a: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
      ovf_a |=> ovf_a);
   a_r8_ovf_sticky_b: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
      ovf_b |=> ovf_b);
endmodule

bind seq_dma_buffer sbuf_checker #(.SEQ_WORDS(SEQ_WORDS)) u_sbuf_checker (
   .clk_bus  (clk_bus),
   .rst_bus_n(rst_bus_n),
   .rd_en    (rd_en),
   .rd_avail (rd_avail),
   .dma_req  (dma_req),
   .dma_last (dma_last),
   .ovf_a    (ovf_a),
   .ovf_b    (ovf_b)
);

// File: tb/test_seq_dma_buffer.sv
module test_seq_dma_buffer;
   localparam int CLK_PERIOD = 15;
   localparam int A_PERIOD   = 5;
   localparam int B_PERIOD   = 7;
   localparam int DEPTH      = 8;
   localparam int SEQ        = 4;

   logic clk_a = 0, clk_b = 0, clk_bus = 0;
   logic rst_a_n = 0, rst_b_n = 0, rst_bus_n = 0;
   logic a_valid = 0, a_last_avg = 0, b_valid = 0, b_last_avg = 0, rd_en = 0;
   logic [15:0] a_data = 0, b_data = 0;
   logic [31:0] rd_data;
   logic rd_avail, dma_req, dma_last, ovf_a, ovf_b;

   always #(A_PERIOD/2.0)   clk_a   = ~clk_a;
   always #(B_PERIOD/2.0)   clk_b   = ~clk_b;
   always #(CLK_PERIOD/2.0) clk_bus = ~clk_bus;

   seq_dma_buffer #(.SAMPLE_W(16), .DEPTH(DEPTH), .SEQ_WORDS(SEQ)) i_seq_dma_buffer (
      .clk_a(clk_a), .rst_a_n(rst_a_n), .a_valid(a_valid), .a_last_avg(a_last_avg), .a_data(a_data),
      .clk_b(clk_b), .rst_b_n(rst_b_n), .b_valid(b_valid), .b_last_avg(b_last_avg), .b_data(b_data),
      .clk_bus(clk_bus), .rst_bus_n(rst_bus_n), .rd_en(rd_en), .rd_data(rd_data),
      .rd_avail(rd_avail), .dma_req(dma_req), .dma_last(dma_last), .ovf_a(ovf_a), .ovf_b(ovf_b)
   );

   int n_cmp = 0, n_bad = 0;
   bit done = 0;
   logic [15:0] qa[$], qb[$];

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   // lane A write: stored only when valid and last both 1 and room exists
   task automatic put_a(input logic [15:0] d, input logic v, input logic l);
      @(negedge clk_a);
      a_valid = v; a_last_avg = l; a_data = d;
      if (v && l && qa.size() < DEPTH) qa.push_back(d);
      @(negedge clk_a);
      a_valid = 0; a_last_avg = 0;
   endtask

   task automatic put_b(input logic [15:0] d, input logic v, input logic l);
      @(negedge clk_b);
      b_valid = v; b_last_avg = l; b_data = d;
      if (v && l && qb.size() < DEPTH) qb.push_back(d);
      @(negedge clk_b);
      b_valid = 0; b_last_avg = 0;
   endtask

   task automatic idle_bus(input int n);
      repeat (n) @(negedge clk_bus);
   endtask

   task automatic read_seq(input string tag);
      int t = 0;
      @(negedge clk_bus);
      while (!dma_req && t < 400) begin @(negedge clk_bus); t++; end
      check(dma_req, {tag, " R10 request raised"}, 32'(dma_req), 1);
      for (int i = 0; i < SEQ; i++) begin
         logic [31:0] exp;
         exp = {qb.pop_front(), qa.pop_front()};
         check(rd_data == exp, {tag, " R4 R5 packed word"}, rd_data, exp);
         check(dma_req == 1'b1, {tag, " R6 request held"}, 32'(dma_req), 1);
         check(dma_last == (i == SEQ-1), {tag, " R6 last flag"}, 32'(dma_last), 32'(i == SEQ-1));
         rd_en = 1;
         @(negedge clk_bus);
      end
      rd_en = 0;
      check(dma_req == 1'b0, {tag, " R6 request dropped after last"}, 32'(dma_req), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk_bus);
      n_bad++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      idle_bus(4);
      rst_a_n = 1; rst_b_n = 1; rst_bus_n = 1;
      idle_bus(2);
      check({dma_req, dma_last, rd_avail, ovf_a, ovf_b} == 5'b0, "R1 reset state",
            32'({dma_req, dma_last, rd_avail, ovf_a, ovf_b}), 0);

      // R2: only valid & last-average samples enter lane A
      for (int i = 0; i < SEQ; i++) begin
         put_a(16'h1000 + 16'(i), 1, 1);
         put_a(16'hDEAD, 1, 0);
         put_a(16'hBEEF, 0, 1);
      end
      for (int i = 0; i < SEQ-1; i++) put_b(16'h2000 + 16'(3*i), 1, 1);
      put_b(16'hCAFE, 0, 0);

      // R3: one lane short of a sequence, R7: pops ignored meanwhile
      rd_en = 1;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk_bus);
         check(!dma_req, "R3 no request with partial lane", 32'(dma_req), 0);
      end
      rd_en = 0;
      check(rd_avail, "R7 data kept while request low", 32'(rd_avail), 1);
      check(rd_data == {16'h2000, 16'h1000}, "R7 head word untouched", rd_data, {16'h2000, 16'h1000});
      put_b(16'h2000 + 16'(3*(SEQ-1)), 1, 1);
      read_seq("seq0 R2");
      check(qa.size() == 0 && qb.size() == 0, "R2 model drained", 32'(qa.size()), 0);

      // sweep of data patterns, single sequences
      for (int r = 1; r < 6; r++) begin
         for (int i = 0; i < SEQ; i++) begin
            put_a(16'(r * 16'h0111) ^ 16'(i << r), 1, 1);
            put_b(~16'(r * 16'h0507 + i), 1, 1);
         end
         read_seq("sweep R5");
      end

      // R10: two queued sequences delivered back to back
      for (int i = 0; i < 2*SEQ; i++) begin
         put_a(16'h8000 | 16'(i), 1, 1);
         put_b(16'h4000 | 16'(i*5), 1, 1);
      end
      idle_bus(20);
      read_seq("R10 first");
      read_seq("R10 second");

      // R8/R9: overfill lane A only
      idle_bus(10);
      for (int i = 0; i < DEPTH+2; i++) put_a(16'h5A00 + 16'(i), 1, 1);
      for (int i = 0; i < DEPTH; i++)   put_b(16'hA500 + 16'(i), 1, 1);
      idle_bus(10);
      check(ovf_a, "R8 overflow flag lane A", 32'(ovf_a), 1);
      check(!ovf_b, "R9 lane B flag unaffected", 32'(ovf_b), 0);
      for (int s = 0; s < DEPTH/SEQ; s++) read_seq("R8 data intact");
      idle_bus(10);
      check(ovf_a, "R8 overflow flag sticky", 32'(ovf_a), 1);
      check(!ovf_b, "R9 lane B flag still clear", 32'(ovf_b), 0);
      check(!dma_req && !rd_avail, "R5 nothing extra stored", 32'({dma_req, rd_avail}), 0);

      report();
   end
endmodule